// File: doc/BRIEF.md
# Precise In-Order Exception Sequencer

This block sits at the retire end of an out-of-order core and decides the cycle in which an exception is taken. Instructions retire to it in program order, one per cycle. Each retiring instruction carries a bitmask of the synchronous conditions it raised. Asynchronous interrupt requests arrive on level inputs and each one has its own enable bit. A synchronous condition can only be taken on the instruction that is retiring. That instruction is the oldest one left, so every older instruction has already finished. Conditions that were detected out of order are therefore still taken in program order.

When one instruction raises several enabled conditions, only the one with the lowest bit index is taken. The instruction is flushed and executes again, and it then returns with the conditions that remain. An interrupt request is latched the cycle it arrives. It is taken only once the execute stage reports that it holds no unfinished work and no instruction is retiring.

When an exception is taken, the block does the following in the same registered step:
- it stores the return address in save register 0;
- it stores the current machine status word in save register 1;
- it sets supervisor mode;
- it raises a one-cycle take strobe, which serves as both the flush of younger instructions and the fetch redirect;
- it presents the vector address.

Top module: `exc_sequencer`

## Requirements
- R1: While reset is held, `take_o`, `sup_mode_o`, `srr0_o`, `srr1_o` and `vec_pc_o` are all zero.
- R2: If `cmp_valid_i` is high with at least one enabled condition bit, then after the next rising edge `take_o` is high for one cycle, `srr0_o` equals that instruction's `cmp_pc_i`, `srr1_o` equals `msr_i` from that cycle, and `sup_mode_o` is 1.
- R3: A synchronous condition at bit index i vectors to VEC_BASE + 0x500 + 0x100·i. Bit 2 is the program condition and vectors to 0x700.
- R4: A condition bit whose `exc_en_i` bit is 0 is ignored. An instruction that carries only masked bits retires with no take, and the save registers keep their values.
- R5: Among several enabled conditions on one instruction, only the lowest index is taken. When the instruction is presented again with the remaining bits, the next lowest index is taken.
- R6: A request pulse on an `irq_req_i` bit that lasts one cycle is held pending until that interrupt is taken.
- R7: A pending enabled interrupt is taken only in a cycle with `exec_empty_i`=1 and `cmp_valid_i`=0, so a retiring synchronous exception goes first. The taken interrupt saves `resume_pc_i` into `srr0_o` and vectors to VEC_BASE + 0x900 + 0x100·j, where j is the lowest enabled pending bit.
- R8: A pending interrupt whose enable bit is 0 is not taken but stays pending. It is taken once it is enabled.
- R9: `take_o` never stays high for two cycles in a row. Inputs presented in the cycle when `take_o` is high (the flush cycle) are ignored.
- R10: A take while `sup_mode_o` is already 1 overwrites both save registers. With no take, the save registers do not change.
- R11: `rfi_i` clears `sup_mode_o` at the next edge. If a take happens in the same cycle, the take wins and `sup_mode_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cmp_valid_i | input | 1 | An instruction retires this cycle |
| cmp_pc_i | input | AW | Address of the retiring instruction |
| cmp_exc_i | input | NSYNC | Synchronous conditions raised by the retiring instruction |
| exc_en_i | input | NSYNC | Enable bit for each synchronous condition |
| irq_req_i | input | NIRQ | Asynchronous interrupt requests (level) |
| irq_en_i | input | NIRQ | Enable bit for each interrupt |
| exec_empty_i | input | 1 | No instruction in execute is still waiting to report |
| resume_pc_i | input | AW | Address of the next instruction to fetch, saved when an interrupt is taken |
| msr_i | input | MW | Current machine status word |
| rfi_i | input | 1 | Return from handler; leaves supervisor mode |
| take_o | output | 1 | One-cycle strobe that flushes younger instructions and redirects fetch |
| vec_pc_o | output | AW | Vector address of the exception just taken |
| srr0_o | output | AW | Save register 0: return address |
| srr1_o | output | MW | Save register 1: saved machine status |
| sup_mode_o | output | 1 | Supervisor mode |

## Verification
The bound checker checks the following on every cycle:
- the take strobe lasts one cycle;
- supervisor mode is set whenever a take is signalled;
- the saved values match the retiring instruction and the status word of the cycle before;
- vectors are aligned to 0x100;
- an interrupt take only follows a cycle with an empty execute stage;
- masked-only retirements cause no take;
- the save registers do not move without a take;
- `rfi_i` clears the mode.

Only the bench scenarios can show the behaviours that depend on history or ordering:
- the exact vector chosen for a set of pending bits;
- the one-at-a-time servicing of several conditions across re-presentations;
- a one-cycle interrupt pulse that survives many busy cycles;
- a disabled interrupt that stays pending until it is enabled;
- a synchronous exception beating an interrupt that is already pending.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int unsigned OFS_W         = 16;
  localparam logic [OFS_W-1:0] SYNC_BASE = 16'h0500;
  localparam logic [OFS_W-1:0] IRQ_BASE  = 16'h0900;
  localparam logic [OFS_W-1:0] OFS_STEP  = 16'h0100;

  // Offset of synchronous condition idx; idx 2 lands on the program vector 0x700.
  function automatic logic [OFS_W-1:0] sync_vec_ofs(input int unsigned idx);
    return SYNC_BASE + OFS_STEP * OFS_W'(idx);
  endfunction

  // Offset of asynchronous interrupt idx.
  function automatic logic [OFS_W-1:0] irq_vec_ofs(input int unsigned idx);
    return IRQ_BASE + OFS_STEP * OFS_W'(idx);
  endfunction

endpackage

// File: rtl/exc_first_set.sv
module exc_first_set #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o,
  output logic [N-1:0]  onehot_o
);
  // seen[i] is high when some bit below index i is set
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_pick
    assign onehot_o[i] = req_i[i] & ~seen[i];
    assign seen[i+1]   = seen[i] | req_i[i];
  end

  assign any_o = seen[N];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot_o[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/exc_irq_latch.sv
module exc_irq_latch #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni) pend_o <= '0;
    else         pend_o <= (pend_o & ~clr_i) | req_i;
  end
endmodule

// File: rtl/exc_save_regs.sv
module exc_save_regs #(
  parameter int unsigned AW = 32,
  parameter int unsigned MW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic          ret_i,
  input  logic [AW-1:0] srr0_d_i,
  input  logic [MW-1:0] srr1_d_i,
  input  logic [AW-1:0] vec_d_i,
  output logic          take_o,
  output logic [AW-1:0] srr0_o,
  output logic [MW-1:0] srr1_o,
  output logic [AW-1:0] vec_o,
  output logic          sup_o
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      take_o <= 1'b0;
      srr0_o <= '0;
      srr1_o <= '0;
      vec_o  <= '0;
      sup_o  <= 1'b0;
    end else begin
      take_o <= take_i;
      if (take_i) begin
        srr0_o <= srr0_d_i;
        srr1_o <= srr1_d_i;
        vec_o  <= vec_d_i;
        sup_o  <= 1'b1;
      end else if (ret_i) begin
        sup_o  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/exc_sequencer.sv
module exc_sequencer #(
  parameter int unsigned AW       = 32,
  parameter int unsigned MW       = 32,
  parameter int unsigned NSYNC    = 4,
  parameter int unsigned NIRQ     = 2,
  parameter logic [AW-1:0] VEC_BASE = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_valid_i,
  input  logic [AW-1:0]    cmp_pc_i,
  input  logic [NSYNC-1:0] cmp_exc_i,
  input  logic [NSYNC-1:0] exc_en_i,
  input  logic [NIRQ-1:0]  irq_req_i,
  input  logic [NIRQ-1:0]  irq_en_i,
  input  logic             exec_empty_i,
  input  logic [AW-1:0]    resume_pc_i,
  input  logic [MW-1:0]    msr_i,
  input  logic             rfi_i,
  output logic             take_o,
  output logic [AW-1:0]    vec_pc_o,
  output logic [AW-1:0]    srr0_o,
  output logic [MW-1:0]    srr1_o,
  output logic             sup_mode_o
);
  import exc_pkg::*;

  localparam int unsigned SIW = (NSYNC > 1) ? $clog2(NSYNC) : 1;
  localparam int unsigned AIW = (NIRQ > 1) ? $clog2(NIRQ) : 1;

  // Named internal events, also used by the bound checker
  logic             sync_any, irq_any;
  logic [SIW-1:0]   sync_idx;
  logic [AIW-1:0]   irq_idx;
  logic [NSYNC-1:0] sync_onehot;
  logic [NIRQ-1:0]  irq_onehot, irq_pend, irq_clr;
  logic             sync_take, irq_take, take_now;
  logic [AW-1:0]    srr0_d, vec_d;

  exc_first_set #(.N(NSYNC), .IW(SIW)) u_sync_pick (
    .req_i    (cmp_exc_i & exc_en_i),
    .any_o    (sync_any),
    .idx_o    (sync_idx),
    .onehot_o (sync_onehot)
  );

  exc_irq_latch #(.N(NIRQ)) u_irq_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (irq_req_i),
    .clr_i  (irq_clr),
    .pend_o (irq_pend)
  );

  exc_first_set #(.N(NIRQ), .IW(AIW)) u_irq_pick (
    .req_i    (irq_pend & irq_en_i),
    .any_o    (irq_any),
    .idx_o    (irq_idx),
    .onehot_o (irq_onehot)
  );

  // Nothing is taken during the flush cycle (take_o high).
  assign sync_take = cmp_valid_i & sync_any & ~take_o;
  assign irq_take  = irq_any & exec_empty_i & ~cmp_valid_i & ~take_o;
  assign take_now  = sync_take | irq_take;
  assign irq_clr   = irq_take ? irq_onehot : '0;

  assign srr0_d = sync_take ? cmp_pc_i : resume_pc_i;
  assign vec_d  = VEC_BASE + (sync_take ? AW'(sync_vec_ofs(32'(sync_idx)))
                                        : AW'(irq_vec_ofs(32'(irq_idx))));

  exc_save_regs #(.AW(AW), .MW(MW)) u_save (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .take_i   (take_now),
    .ret_i    (rfi_i),
    .srr0_d_i (srr0_d),
    .srr1_d_i (msr_i),
    .vec_d_i  (vec_d),
    .take_o   (take_o),
    .srr0_o   (srr0_o),
    .srr1_o   (srr1_o),
    .vec_o    (vec_pc_o),
    .sup_o    (sup_mode_o)
  );
endmodule

// File: rtl/exc_sequencer_chk.sv
module exc_sequencer_chk #(
  parameter int unsigned AW       = 32,
  parameter int unsigned MW       = 32,
  parameter int unsigned NSYNC    = 4,
  parameter logic [AW-1:0] VEC_BASE = '0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmp_valid_i,
  input logic [AW-1:0]    cmp_pc_i,
  input logic [NSYNC-1:0] cmp_exc_i,
  input logic [NSYNC-1:0] exc_en_i,
  input logic             exec_empty_i,
  input logic [MW-1:0]    msr_i,
  input logic             rfi_i,
  input logic             take_o,
  input logic [AW-1:0]    vec_pc_o,
  input logic [AW-1:0]    srr0_o,
  input logic [MW-1:0]    srr1_o,
  input logic             sup_mode_o,
  input logic             sync_take,
  input logic             irq_take
);
  AST_TAKE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !take_o);                                                  // R9
  AST_SUP_ON_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> sup_mode_o);                                               // R2
  AST_SRR0_FROM_RETIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_take |=> (srr0_o == $past(cmp_pc_i)));                           // R2
  AST_SRR1_FROM_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_take || irq_take) |=> (srr1_o == $past(msr_i)));                // R2
  AST_VEC_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (vec_pc_o[7:0] == VEC_BASE[7:0]));                         // R3
  AST_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_valid_i && ((cmp_exc_i & exc_en_i) == '0) && !exec_empty_i) |=> !take_o); // R4
  AST_IRQ_AFTER_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && !$past(cmp_valid_i)) |-> $past(exec_empty_i));             // R7
  AST_SRR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_take && !irq_take) |=> ($stable(srr0_o) && $stable(srr1_o)));  // R10
  AST_RFI_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rfi_i && !sync_take && !irq_take) |=> !sup_mode_o);                  // R11
endmodule

bind exc_sequencer exc_sequencer_chk #(
  .AW(AW), .MW(MW), .NSYNC(NSYNC), .VEC_BASE(VEC_BASE)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmp_valid_i  (cmp_valid_i),
  .cmp_pc_i     (cmp_pc_i),
  .cmp_exc_i    (cmp_exc_i),
  .exc_en_i     (exc_en_i),
  .exec_empty_i (exec_empty_i),
  .msr_i        (msr_i),
  .rfi_i        (rfi_i),
  .take_o       (take_o),
  .vec_pc_o     (vec_pc_o),
  .srr0_o       (srr0_o),
  .srr1_o       (srr1_o),
  .sup_mode_o   (sup_mode_o),
  .sync_take    (sync_take),
  .irq_take     (irq_take)
);

// File: tb/exc_sequencer_tb.sv
module exc_sequencer_tb;
  localparam int unsigned AW = 32, MW = 32, NS = 4, NI = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          cmp_valid, exec_empty, rfi;
  logic [AW-1:0] cmp_pc, resume_pc;
  logic [NS-1:0] cmp_exc, exc_en;
  logic [NI-1:0] irq_req, irq_en;
  logic [MW-1:0] msr;
  logic          take_o, sup_mode_o;
  logic [AW-1:0] vec_pc_o, srr0_o;
  logic [MW-1:0] srr1_o;

  exc_sequencer #(.AW(AW), .MW(MW), .NSYNC(NS), .NIRQ(NI)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmp_valid_i(cmp_valid), .cmp_pc_i(cmp_pc),
    .cmp_exc_i(cmp_exc), .exc_en_i(exc_en), .irq_req_i(irq_req), .irq_en_i(irq_en),
    .exec_empty_i(exec_empty), .resume_pc_i(resume_pc), .msr_i(msr), .rfi_i(rfi),
    .take_o(take_o), .vec_pc_o(vec_pc_o), .srr0_o(srr0_o), .srr1_o(srr1_o),
    .sup_mode_o(sup_mode_o)
  );

  typedef struct { logic [31:0] vec, s0, s1; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic push(logic [31:0] vec, logic [31:0] s0, logic [31:0] s1, string tag);
    exp_t e;
    e.vec = vec; e.s0 = s0; e.s1 = s1; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle();
    cmp_valid = 1'b0; cmp_exc = '0; irq_req = '0; rfi = 1'b0;
  endtask

  task automatic retire(logic [31:0] pc, logic [NS-1:0] exc, logic [31:0] st);
    cmp_valid = 1'b1; cmp_pc = pc; cmp_exc = exc; msr = st;
  endtask

  // Monitor: every take is compared with the next queued expectation
  always @(negedge clk) begin
    if (rst_n && take_o) begin
      if (q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R4 R9: unexpected take, actual vec %h expected none", vec_pc_o);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, "vector", vec_pc_o, e.vec);
        chk(e.tag, "srr0", srr0_o, e.s0);
        chk(e.tag, "srr1", srr1_o, e.s1);
        chk(e.tag, "supervisor", {31'b0, sup_mode_o}, 32'd1);
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    idle(); exc_en = '1; irq_en = '1; exec_empty = 1'b0;
    resume_pc = '0; msr = '0; cmp_pc = '0;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1", "take", {31'b0, take_o}, 0);
    chk("R1", "sup", {31'b0, sup_mode_o}, 0);
    chk("R1", "srr0", srr0_o, 0);
    chk("R1", "srr1", srr1_o, 0);
    chk("R1", "vec", vec_pc_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3: program condition (bit 2) -> 0x700
    retire(32'h1000, 4'b0100, 32'hAA); push(32'h700, 32'h1000, 32'hAA, "R3");
    @(negedge clk); idle();
    @(negedge clk);
    chk("R2", "sup after take", {31'b0, sup_mode_o}, 1);

    // R5: bits 1 and 3 -> bit 1 first, then 3 on re-presentation
    retire(32'h2000, 4'b1010, 32'h11); push(32'h600, 32'h2000, 32'h11, "R5");
    @(negedge clk); idle();
    @(negedge clk);
    retire(32'h2000, 4'b1000, 32'h12); push(32'h800, 32'h2000, 32'h12, "R5");
    @(negedge clk); idle();
    @(negedge clk);

    // R4: only a masked bit raised
    exc_en = 4'b1011;
    retire(32'h2100, 4'b0100, 32'h13);
    @(negedge clk); idle();
    chk("R4", "take", {31'b0, take_o}, 0);
    chk("R4", "srr0 kept", srr0_o, 32'h2000);
    exc_en = '1;
    @(negedge clk);

    // R9: retirement during flush cycle is ignored
    retire(32'h3000, 4'b0001, 32'h33); push(32'h500, 32'h3000, 32'h33, "R9");
    @(negedge clk);
    retire(32'h3004, 4'b0001, 32'h34);
    @(negedge clk); idle();
    chk("R9", "take after flush", {31'b0, take_o}, 0);
    chk("R9", "srr0", srr0_o, 32'h3000);
    @(negedge clk);

    // R6 R7 R8: interrupt pulses while execute busy
    irq_en = 2'b01; irq_req = 2'b10;
    @(negedge clk); irq_req = 2'b01;
    @(negedge clk); irq_req = '0; resume_pc = 32'h4000; msr = 32'h44;
    repeat (3) @(negedge clk);
    chk("R7", "no take while busy", {31'b0, take_o}, 0);
    exec_empty = 1'b1; push(32'h900, 32'h4000, 32'h44, "R6");
    @(negedge clk);
    @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R8", "disabled stays quiet", {31'b0, take_o}, 0);
    chk("R8", "srr0", srr0_o, 32'h4000);
    irq_en = 2'b11; resume_pc = 32'h4100; msr = 32'h45;
    push(32'hA00, 32'h4100, 32'h45, "R8");
    @(negedge clk);
    @(negedge clk); exec_empty = 1'b0;
    @(negedge clk);

    // R7: retiring sync exception beats a pending interrupt
    irq_req = 2'b01;
    @(negedge clk); irq_req = '0;
    exec_empty = 1'b1; resume_pc = 32'h5100;
    retire(32'h5000, 4'b0001, 32'h55); push(32'h500, 32'h5000, 32'h55, "R7");
    @(negedge clk); idle();
    @(negedge clk); msr = 32'h56; push(32'h900, 32'h5100, 32'h56, "R7");
    @(negedge clk); exec_empty = 1'b0;
    @(negedge clk);
    // R10: nested takes overwrote the save registers
    chk("R10", "sup", {31'b0, sup_mode_o}, 1);
    chk("R10", "srr0", srr0_o, 32'h5100);
    chk("R10", "srr1", srr1_o, 32'h56);

    // R11: return clears mode; take wins over return
    rfi = 1'b1;
    @(negedge clk); rfi = 1'b0;
    chk("R11", "sup cleared", {31'b0, sup_mode_o}, 0);
    rfi = 1'b1; retire(32'h6000, 4'b0010, 32'h66); push(32'h600, 32'h6000, 32'h66, "R11");
    @(negedge clk); idle();
    chk("R11", "take wins", {31'b0, sup_mode_o}, 1);

    repeat (3) @(negedge clk);
    chk("R2", "queue drained", q.size(), 0);
    finish_run();
  end
endmodule